// File: doc/BRIEF.md
# Double-Buffered Receive Endpoint FIFO

This block buffers OUT packets arriving from a USB function core so the CPU can read them at its own pace. It holds two banks of 64 bytes each. The USB side fills one bank byte by byte and marks the last byte with an end-of-packet strobe. That bank then becomes readable while the other bank takes the next packet. The CPU reads bytes one at a time from the readable bank and sees that bank's byte count. When it has read what it needs, it pulses a read-finished trigger. The trigger hands the CPU the other bank and returns the drained bank to the USB side.

The block never overwrites a packet that has not been read. When both banks hold packets, it drops its ready indication and ignores incoming bytes. It refuses reads past the packet length and raises an error flag instead. A clear input empties both banks, for example after the cable is pulled. The clear only takes effect in a cycle with no transfer activity on either side.

Top module: `pp_rx_fifo`

## Requirements
- R1: After reset, usb_ready is 1, data_avail is 0, cpu_rx_size is 0 and rd_err is 0.
- R2: A packet whose last byte is written together with usb_pkt_end is committed at that clock edge. From the next cycle, data_avail is 1 and cpu_rx_size equals the number of bytes written. A usb_pkt_end with no byte gives a zero-length packet.
- R3: Each cpu_rd pulse while fewer than cpu_rx_size bytes have been read returns the next byte of the packet, in the order written. cpu_rd_data shows that byte in the cycle after the pulse.
- R4: A cpu_rd pulse once cpu_rx_size bytes have been read (or when no packet is readable) leaves cpu_rd_data unchanged and sets rd_err from the next cycle. rd_err stays 1 until a read-finished trigger or an accepted clear.
- R5: A cpu_rd_done pulse while data_avail is 1 switches the readable bank to the other bank from the next cycle. cpu_rx_size then shows that bank's byte count, or 0 with data_avail 0 if it is empty. rd_err is cleared and reading restarts at the packet's first byte.
- R6: The same trigger frees the drained bank: if both banks were full, usb_ready returns to 1 in the next cycle.
- R7: While both banks hold unread packets, usb_ready is 0. Written bytes and usb_pkt_end are ignored, and the stored packets and their counts are unchanged.
- R8: A cpu_clr pulse in a cycle with no usb_wr_valid, usb_pkt_end or cpu_rd empties both banks and discards any partly received packet. From the next cycle, data_avail is 0, cpu_rx_size is 0, rd_err is 0 and usb_ready is 1.
- R9: A cpu_clr pulse in a cycle where usb_wr_valid, usb_pkt_end or cpu_rd is 1 has no effect. A readable packet stays readable with its count.
- R10: A bank stores at most 64 bytes per packet. Bytes beyond 64 in one packet are dropped, and cpu_rx_size reports 64.
- R11: A cpu_rd_done pulse while data_avail is 0 is ignored. The next packet received is the one the CPU reads.
- R12: Packets are presented to the CPU in arrival order, alternating between the two banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| usb_wr_valid | input | 1 | A received byte is present on usb_wr_data |
| usb_wr_data | input | 8 | Received byte |
| usb_pkt_end | input | 1 | Ends the current packet (may coincide with its last byte) |
| usb_ready | output | 1 | A bank is free to receive; 0 means not ready (NAK) |
| cpu_rd | input | 1 | Read one byte from the readable bank |
| cpu_rd_data | output | 8 | Byte returned by the last accepted read |
| cpu_rx_size | output | 7 | Byte count of the readable bank, 0 if none |
| cpu_rd_done | input | 1 | Read-finished trigger |
| cpu_clr | input | 1 | Empty both banks |
| data_avail | output | 1 | The readable bank holds a complete packet |
| rd_err | output | 1 | A read past the packet length was attempted |

## Verification
A wrong bank index on either side shows up within one packet. If the write side and the read side disagree on the bank, a committed packet leaves data_avail low, or the CPU reads another packet's bytes. A lost or stale full flag shows as usb_ready wrongly high or low right after the second commit or after a trigger. A read pointer that is not reset or not bounded shows on the first byte after a trigger, or as rd_err failing to rise on the read that follows the last valid byte. A clear accepted during activity, or refused when idle, changes data_avail and cpu_rx_size in the very next cycle.

// File: rtl/pp_rx_pkg.sv
package pp_rx_pkg;

  typedef enum logic {
    BANK_A = 1'b0,
    BANK_B = 1'b1
  } bank_e;

  function automatic bank_e other_bank(input bank_e b);
    return (b == BANK_A) ? BANK_B : BANK_A;
  endfunction

endpackage

// File: rtl/pp_bank_mem.sv
module pp_bank_mem #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pp_wr_ctrl.sv
module pp_wr_ctrl
  import pp_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_ok,
  input  logic             wr_valid,
  input  logic             pkt_end,
  input  logic             bank_ready,
  output logic             wr_accept,
  output logic             commit,
  output logic [CNT_W-1:0] commit_cnt,
  output logic [PTR_W-1:0] wr_addr,
  output bank_e            fill_sel
);

  logic [CNT_W-1:0] wr_cnt;

  // room left in the bank being filled
  function automatic logic has_room(input logic [CNT_W-1:0] c);
    return c < CNT_W'(DEPTH);
  endfunction

  // byte count once this cycle's accepted byte is included
  function automatic logic [CNT_W-1:0] cnt_after(input logic [CNT_W-1:0] c,
                                                 input logic acc);
    return c + {{(CNT_W-1){1'b0}}, acc};
  endfunction

  assign wr_accept  = wr_valid & bank_ready & has_room(wr_cnt);
  assign commit     = pkt_end & bank_ready;
  assign commit_cnt = cnt_after(wr_cnt, wr_accept);
  assign wr_addr    = wr_cnt[PTR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt   <= '0;
      fill_sel <= BANK_A;
    end else if (clr_ok) begin
      wr_cnt   <= '0;
      fill_sel <= BANK_A;
    end else if (commit) begin
      wr_cnt   <= '0;
      fill_sel <= other_bank(fill_sel);
    end else if (wr_accept) begin
      wr_cnt   <= cnt_after(wr_cnt, 1'b1);
    end
  end

  // R10: the fill count never passes the bank depth
  a_r10_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt <= CNT_W'(DEPTH));

  // R2: a commit hands the other bank to the USB side
  a_r2_fill_swaps: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !clr_ok |=> fill_sel != $past(fill_sel));

endmodule

// File: rtl/pp_rd_ctrl.sv
module pp_rd_ctrl
  import pp_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_ok,
  input  logic              rd,
  input  logic              done,
  input  logic              avail,
  input  logic [CNT_W-1:0]  size,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [PTR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err,
  output bank_e             cpu_sel,
  output logic              release_bank
);

  logic [CNT_W-1:0] rd_ptr;
  logic             rd_ok;

  // a read is honoured only while unread bytes remain
  function automatic logic can_read(input logic [CNT_W-1:0] p,
                                    input logic [CNT_W-1:0] s);
    return p < s;
  endfunction

  assign rd_ok        = rd & can_read(rd_ptr, size);
  assign release_bank = done & avail;
  assign rd_addr      = rd_ptr[PTR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      rd_data <= '0;
      rd_err  <= 1'b0;
      cpu_sel <= BANK_A;
    end else if (clr_ok) begin
      rd_ptr  <= '0;
      rd_err  <= 1'b0;
      cpu_sel <= BANK_A;
    end else if (release_bank) begin
      rd_ptr  <= '0;
      rd_err  <= 1'b0;
      cpu_sel <= other_bank(cpu_sel);
    end else if (rd_ok) begin
      rd_ptr  <= rd_ptr + 1'b1;
      rd_data <= mem_rdata;
    end else if (rd) begin
      rd_err  <= 1'b1;
    end
  end

  // R4: the read pointer never runs past the readable count
  a_r4_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= size);

  // R4: the error flag only rises as a result of a read request
  a_r4_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_err) |-> $past(rd));

  // R5: the trigger moves the CPU to the other bank and restarts the pointer
  a_r5_sel_swaps: assert property (@(posedge clk) disable iff (!rst_n)
    release_bank && !clr_ok |=> cpu_sel != $past(cpu_sel) && rd_ptr == '0);

endmodule

// File: rtl/pp_rx_fifo.sv
module pp_rx_fifo
  import pp_rx_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              usb_wr_valid,
  input  logic [DATA_W-1:0] usb_wr_data,
  input  logic              usb_pkt_end,
  output logic              usb_ready,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rd_data,
  output logic [CNT_W-1:0]  cpu_rx_size,
  input  logic              cpu_rd_done,
  input  logic              cpu_clr,
  output logic              data_avail,
  output logic              rd_err
);

  localparam int PTR_W  = $clog2(DEPTH);
  localparam int NBANKS = 2;

  // named internal events
  logic              busy;
  logic              clr_ok;
  logic              wr_accept;
  logic              commit;
  logic [CNT_W-1:0]  commit_cnt;
  logic [PTR_W-1:0]  wr_addr;
  logic [PTR_W-1:0]  rd_addr;
  logic              release_bank;
  bank_e             fill_sel;
  bank_e             cpu_sel;

  logic [NBANKS-1:0] bank_full;
  logic [CNT_W-1:0]  bank_cnt   [NBANKS];
  logic [DATA_W-1:0] bank_rdata [NBANKS];
  logic [DATA_W-1:0] sel_rdata;

  assign busy      = usb_wr_valid | usb_pkt_end | cpu_rd;
  assign clr_ok    = cpu_clr & ~busy;
  assign usb_ready = ~bank_full[fill_sel];

  assign data_avail  = bank_full[cpu_sel];
  assign cpu_rx_size = data_avail ? bank_cnt[cpu_sel] : '0;
  assign sel_rdata   = bank_rdata[cpu_sel];

  pp_wr_ctrl #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .PTR_W (PTR_W)
  ) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_ok     (clr_ok),
    .wr_valid   (usb_wr_valid),
    .pkt_end    (usb_pkt_end),
    .bank_ready (usb_ready),
    .wr_accept  (wr_accept),
    .commit     (commit),
    .commit_cnt (commit_cnt),
    .wr_addr    (wr_addr),
    .fill_sel   (fill_sel)
  );

  pp_rd_ctrl #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .PTR_W  (PTR_W)
  ) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_ok       (clr_ok),
    .rd           (cpu_rd),
    .done         (cpu_rd_done),
    .avail        (data_avail),
    .size         (cpu_rx_size),
    .mem_rdata    (sel_rdata),
    .rd_addr      (rd_addr),
    .rd_data      (cpu_rd_data),
    .rd_err       (rd_err),
    .cpu_sel      (cpu_sel),
    .release_bank (release_bank)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic is_fill;
    logic is_cpu;
    assign is_fill = (fill_sel == bank_e'(b));
    assign is_cpu  = (cpu_sel == bank_e'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_full[b] <= 1'b0;
        bank_cnt[b]  <= '0;
      end else if (clr_ok) begin
        bank_full[b] <= 1'b0;
        bank_cnt[b]  <= '0;
      end else if (commit && is_fill) begin
        bank_full[b] <= 1'b1;
        bank_cnt[b]  <= commit_cnt;
      end else if (release_bank && is_cpu) begin
        bank_full[b] <= 1'b0;
      end
    end

    pp_bank_mem #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W),
      .PTR_W  (PTR_W)
    ) u_mem (
      .clk   (clk),
      .we    (wr_accept && is_fill),
      .waddr (wr_addr),
      .wdata (usb_wr_data),
      .raddr (rd_addr),
      .rdata (bank_rdata[b])
    );

    // R7: a full bank keeps its count until it is released or cleared
    a_r7_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
      bank_full[b] && $past(bank_full[b]) && !$past(clr_ok) |-> $stable(bank_cnt[b]));
  end

  // R7: both banks occupied means the USB side is told not ready
  a_r7_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (&bank_full) |-> !usb_ready);

  // R2: a commit makes its bank full on the next cycle
  a_r2_commit_fills: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !clr_ok |=> bank_full[$past(fill_sel)]);

  // R8: an accepted clear leaves nothing readable
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ok |=> !data_avail && usb_ready && cpu_rx_size == '0);

  // R9: a clear during activity leaves a readable packet readable
  a_r9_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clr && busy && data_avail && !cpu_rd_done |=> data_avail);

endmodule

// File: tb/tb_pp_rx_fifo.sv
`timescale 1ns/1ps
module tb_pp_rx_fifo;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       usb_wr_valid = 1'b0;
  logic [7:0] usb_wr_data = '0;
  logic       usb_pkt_end = 1'b0;
  logic       usb_ready;
  logic       cpu_rd = 1'b0;
  logic [7:0] cpu_rd_data;
  logic [6:0] cpu_rx_size;
  logic       cpu_rd_done = 1'b0;
  logic       cpu_clr = 1'b0;
  logic       data_avail;
  logic       rd_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pp_rx_fifo dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .usb_wr_valid (usb_wr_valid),
    .usb_wr_data  (usb_wr_data),
    .usb_pkt_end  (usb_pkt_end),
    .usb_ready    (usb_ready),
    .cpu_rd       (cpu_rd),
    .cpu_rd_data  (cpu_rd_data),
    .cpu_rx_size  (cpu_rx_size),
    .cpu_rd_done  (cpu_rd_done),
    .cpu_clr      (cpu_clr),
    .data_avail   (data_avail),
    .rd_err       (rd_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // n bytes base, base+1, ...; the end strobe rides on the last byte
  task automatic usb_send(input int n, input logic [7:0] base);
    if (n == 0) begin
      usb_pkt_end = 1'b1;
      @(negedge clk);
      usb_pkt_end = 1'b0;
    end else begin
      for (int i = 0; i < n; i++) begin
        usb_wr_valid = 1'b1;
        usb_wr_data  = base + 8'(i);
        usb_pkt_end  = (i == n - 1);
        @(negedge clk);
      end
      usb_wr_valid = 1'b0;
      usb_pkt_end  = 1'b0;
    end
  endtask

  task automatic cpu_read1();
    cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
  endtask

  task automatic cpu_done();
    cpu_rd_done = 1'b1;
    @(negedge clk);
    cpu_rd_done = 1'b0;
  endtask

  // reads n bytes and returns the number of mismatches against base+i
  task automatic read_pkt(input int n, input logic [7:0] base, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      cpu_read1();
      if (cpu_rd_data != base + 8'(i)) bad++;
    end
  endtask

  task automatic t_reset();
    chk("R1", "usb_ready", usb_ready, 1);
    chk("R1", "data_avail", data_avail, 0);
    chk("R1", "rx_size", cpu_rx_size, 0);
    chk("R1", "rd_err", rd_err, 0);
  endtask

  task automatic t_single();
    int bad;
    usb_send(5, 8'h10);
    chk("R2", "data_avail after commit", data_avail, 1);
    chk("R2", "rx_size after commit", cpu_rx_size, 5);
    read_pkt(5, 8'h10, bad);
    chk("R3", "byte mismatches", bad, 0);
    chk("R3", "no error within count", rd_err, 0);
    cpu_done();
    chk("R5", "data_avail after trigger on empty other bank", data_avail, 0);
    chk("R5", "rx_size after trigger", cpu_rx_size, 0);
  endtask

  task automatic t_overread();
    int bad;
    usb_send(3, 8'h40);
    read_pkt(3, 8'h40, bad);
    chk("R3", "byte mismatches", bad, 0);
    cpu_read1();
    chk("R4", "rd_err after overread", rd_err, 1);
    chk("R4", "rd_data unchanged", cpu_rd_data, 8'h42);
    cpu_read1();
    chk("R4", "rd_err sticks", rd_err, 1);
    cpu_done();
    chk("R5", "rd_err cleared by trigger", rd_err, 0);
    // zero-length packet: readable but nothing to read
    usb_send(0, 8'h00);
    chk("R2", "zero-length avail", data_avail, 1);
    chk("R2", "zero-length size", cpu_rx_size, 0);
    cpu_read1();
    chk("R4", "rd_err on empty packet", rd_err, 1);
    chk("R4", "rd_data unchanged on empty packet", cpu_rd_data, 8'h42);
    cpu_done();
  endtask

  task automatic t_both_full();
    int bad;
    usb_send(4, 8'h20);
    chk("R7", "ready after one packet", usb_ready, 1);
    usb_send(6, 8'h30);
    chk("R7", "not ready with both banks full", usb_ready, 0);
    usb_send(2, 8'hE0);
    chk("R7", "size kept while blocked", cpu_rx_size, 4);
    read_pkt(4, 8'h20, bad);
    chk("R12", "first packet bytes", bad, 0);
    cpu_done();
    chk("R6", "ready after freeing a bank", usb_ready, 1);
    chk("R5", "size of second bank", cpu_rx_size, 6);
    read_pkt(6, 8'h30, bad);
    chk("R12", "second packet bytes", bad, 0);
    cpu_done();
    chk("R7", "blocked packet not stored", data_avail, 0);
  endtask

  task automatic t_clear_busy();
    usb_send(7, 8'h50);
    cpu_clr = 1'b1;
    cpu_rd  = 1'b1;
    @(negedge clk);
    cpu_clr = 1'b0;
    cpu_rd  = 1'b0;
    chk("R9", "avail kept when clear collides with read", data_avail, 1);
    chk("R9", "size kept", cpu_rx_size, 7);
    cpu_clr      = 1'b1;
    usb_wr_valid = 1'b1;
    usb_wr_data  = 8'h99;
    @(negedge clk);
    cpu_clr      = 1'b0;
    usb_wr_valid = 1'b0;
    chk("R9", "avail kept when clear collides with write", data_avail, 1);
  endtask

  task automatic t_clear_idle();
    int bad;
    // second bank holds one partial byte from t_clear_busy; clear drops all
    cpu_read1();
    cpu_read1();
    cpu_read1();
    cpu_read1();
    cpu_read1();
    cpu_read1();
    cpu_read1();
    cpu_read1();
    chk("R4", "overread before clear", rd_err, 1);
    cpu_clr = 1'b1;
    @(negedge clk);
    cpu_clr = 1'b0;
    chk("R8", "avail after clear", data_avail, 0);
    chk("R8", "size after clear", cpu_rx_size, 0);
    chk("R8", "rd_err after clear", rd_err, 0);
    chk("R8", "ready after clear", usb_ready, 1);
    usb_send(3, 8'h70);
    chk("R8", "fresh packet size", cpu_rx_size, 3);
    read_pkt(3, 8'h70, bad);
    chk("R8", "partial byte discarded", bad, 0);
    cpu_done();
  endtask

  task automatic t_oversize();
    int bad;
    usb_send(70, 8'h80);
    chk("R10", "size saturates", cpu_rx_size, 64);
    read_pkt(64, 8'h80, bad);
    chk("R10", "first 64 bytes", bad, 0);
    cpu_read1();
    chk("R10", "65th read refused", rd_err, 1);
    cpu_done();
  endtask

  task automatic t_done_empty();
    int bad;
    cpu_done();
    chk("R11", "avail stays low", data_avail, 0);
    chk("R11", "ready stays high", usb_ready, 1);
    usb_send(2, 8'hA0);
    chk("R11", "next packet visible", data_avail, 1);
    read_pkt(2, 8'hA0, bad);
    chk("R11", "next packet bytes", bad, 0);
    cpu_done();
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_overread();
    t_both_full();
    t_clear_busy();
    t_clear_idle();
    t_oversize();
    t_done_empty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule